// File: doc/BRIEF.md
# Reset Release and Start-Vector Sequencer

This block decides when a small 8-bit processor leaves reset and where it starts executing. It runs on the crystal clock. An active-low external reset passes through a synchroniser. While that reset is low, a fixed prescaler and two chained down-counters are loaded with their preset values. Once reset is released, the prescaler divides the crystal clock by 16. The first counter steps on each prescaler tick, and every wrap of the first counter steps the second. The internal reset drops when the second counter wraps, after exactly 16 × 256 × 8 = 32768 counted crystal cycles.

After the internal reset drops, a processor-clock enable runs at half the crystal rate. The block then drives one address per processor cycle:

- three dummy cycles in the stack page, at the stack pointer value and then one and two below it, with the read strobe inactive;
- two strobed reads at the vector pair, low byte first;
- the start address built from the two bytes it read. A done flag marks the first processor cycle of that address, and the address stays on the bus afterwards.

Asserting reset again at any time restarts the whole sequence.

Top module: `reset_vector_seq`

## Requirements
- R1: While intRst is high, phiEn is low. From the first clock edge after intRst falls, phiEn alternates on every clock edge, starting low. One processor cycle is one low phase followed by one high phase of phiEn.
- R2: intRst falls on the 32770th rising clock edge that samples rstExtN high. That is two synchroniser stages plus 32768 counted cycles, from a /16 prescaler, a 256-step counter and an 8-step counter.
- R3: While rstExtN is low, the outputs are forced at once to intRst = 1, phiEn = 0, addr = 0x0000, rdStb = 0 and done = 0. The same values hold until intRst falls.
- R4: The first three processor cycles after intRst falls drive addr = {0x01, S}, then {0x01, S-1}, then {0x01, S-2}, with rdStb low. S is spInit, and the low byte wraps modulo 256.
- R5: The next two processor cycles drive addr = 0xFFFE and then 0xFFFF, with rdStb high for both.
- R6: rdData is captured at the end of each strobed cycle. From the sixth processor cycle on, addr and startPc both equal {byte read at 0xFFFF, byte read at 0xFFFE}, and rdStb stays low.
- R7: done is high for exactly the sixth processor cycle (two clock cycles) and low at all other times.
- R8: Driving rstExtN low during the delay or during the address sequence restarts everything. The full delay of R2 and the sequence of R4 to R7 repeat after the next release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rstExtN | input | 1 | External reset, active low, asynchronous |
| spInit | input | 8 | Stack pointer value S used for the dummy cycles |
| rdData | input | 8 | Read data returned for the vector reads |
| intRst | output | 1 | Internal reset, active high |
| phiEn | output | 1 | Processor-clock phase, high in the second half of each processor cycle |
| addr | output | 16 | Address bus |
| rdStb | output | 1 | Read strobe, high on the vector cycles only |
| startPc | output | 16 | Start address assembled from the vector bytes |
| done | output | 1 | High for the first processor cycle of the start address |

## Verification
The hardest case to reach is a reset that lands in the middle of the vector reads. The strobe and the half-captured start address must be dropped, and a different stack pointer and vector must then take effect. The stimulus lets one full delay expire and counts clock edges until the low-byte read is under way. It then pulses rstExtN low and changes spInit to 0x01 and the vector to 0xBEEF while reset is held. On the following run, the model checks the 32770-edge delay again, the stack-page wrap to 0xFF and the new start address. A second re-arm, 10000 edges into a delay, covers a reset taken while the counters are part-way through.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_STK0,
    ST_STK1,
    ST_STK2,
    ST_VECL,
    ST_VECH,
    ST_PCOUT,
    ST_FIN
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_IDLE,
    SEL_STACK,
    SEL_VECTOR,
    SEL_START
  } addrSel_t;

  typedef struct packed {
    logic     countEn;
    logic     phiRun;
    addrSel_t addrSel;
    logic [1:0] stkOff;
    logic     vecHi;
    logic     rdStb;
    logic     latchLo;
    logic     latchHi;
  } seqCmd_t;

endpackage

// File: rtl/rvs_sync.sv
module rvs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncN,
  output logic syncN
);

  generate
    if (STAGES >= 2) begin : gChain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge asyncN) begin
        if (!asyncN) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
      end
      assign syncN = chain[STAGES-1];
    end else begin : gSingle
      logic stage;
      always_ff @(posedge clk or negedge asyncN) begin
        if (!asyncN) stage <= 1'b0;
        else         stage <= 1'b1;
      end
      assign syncN = stage;
    end
  endgenerate

endmodule

// File: rtl/rvs_datapath.sv
module rvs_datapath
  import rvs_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PRESC_DIV  = 16,
  parameter int T_LO_INIT  = 255,
  parameter int T_HI_INIT  = 7,
  parameter int STACK_PAGE = 1,
  parameter int VEC_ADDR   = 16'hFFFE
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqCmd_t               cmd,
  input  logic [DATA_W-1:0]     spInit,
  input  logic [DATA_W-1:0]     rdData,
  output logic                  expire,
  output logic                  phase,
  output logic [2*DATA_W-1:0]   addr,
  output logic [2*DATA_W-1:0]   startPc
);

  localparam int AW = 2 * DATA_W;
  localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int NT = 2;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0]     presc;
  logic              tick;
  logic [NT:0]       carry;
  logic [DATA_W-1:0] vecLoQ, vecHiQ;

  // Prescaler: one tick every PRESC_DIV crystal cycles while counting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            presc <= '0;
    else if (cmd.countEn) presc <= (presc == PRESC_LAST) ? '0 : presc + 1'b1;
  end
  assign tick     = cmd.countEn && (presc == PRESC_LAST);
  assign carry[0] = tick;

  // Chained down-counters, each reloading its preset on wrap
  generate
    for (genvar g = 0; g < NT; g++) begin : gTimer
      localparam logic [DATA_W-1:0] INIT =
        (g == 0) ? DATA_W'(T_LO_INIT) : DATA_W'(T_HI_INIT);
      logic [DATA_W-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)         cnt <= INIT;
        else if (carry[g]) cnt <= (cnt == '0) ? INIT : cnt - 1'b1;
      end
      assign carry[g+1] = carry[g] && (cnt == '0);
    end
  endgenerate

  assign expire = carry[NT];

  // Processor clock phase: half the crystal rate once running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= cmd.phiRun ? ~phase : 1'b0;
  end

  // Vector byte capture at the end of each strobed cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecLoQ <= '0;
      vecHiQ <= '0;
    end else begin
      if (cmd.latchLo) vecLoQ <= rdData;
      if (cmd.latchHi) vecHiQ <= rdData;
    end
  end

  assign startPc = {vecHiQ, vecLoQ};

  // Address selection
  always_comb begin
    case (cmd.addrSel)
      SEL_STACK:  addr = {DATA_W'(STACK_PAGE), spInit - DATA_W'(cmd.stkOff)};
      SEL_VECTOR: addr = AW'(VEC_ADDR) + AW'(cmd.vecHi);
      SEL_START:  addr = startPc;
      default:    addr = '0;
    endcase
  end

endmodule

// File: rtl/rvs_ctrl.sv
module rvs_ctrl
  import rvs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    expire,
  input  logic    phase,
  output seqCmd_t cmd,
  output logic    intRst,
  output logic    done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  // Sequence steps on the last crystal cycle of each processor cycle
  always_comb begin
    stateNext = state;
    case (state)
      ST_HOLD:  if (expire) stateNext = ST_STK0;
      ST_STK0:  if (phase)  stateNext = ST_STK1;
      ST_STK1:  if (phase)  stateNext = ST_STK2;
      ST_STK2:  if (phase)  stateNext = ST_VECL;
      ST_VECL:  if (phase)  stateNext = ST_VECH;
      ST_VECH:  if (phase)  stateNext = ST_PCOUT;
      ST_PCOUT: if (phase)  stateNext = ST_FIN;
      default:              stateNext = ST_FIN;
    endcase
  end

  always_comb begin
    cmd         = '0;
    cmd.addrSel = SEL_IDLE;
    cmd.countEn = (state == ST_HOLD);
    cmd.phiRun  = (state != ST_HOLD);
    case (state)
      ST_STK0: begin cmd.addrSel = SEL_STACK; cmd.stkOff = 2'd0; end
      ST_STK1: begin cmd.addrSel = SEL_STACK; cmd.stkOff = 2'd1; end
      ST_STK2: begin cmd.addrSel = SEL_STACK; cmd.stkOff = 2'd2; end
      ST_VECL: begin
        cmd.addrSel = SEL_VECTOR;
        cmd.rdStb   = 1'b1;
        cmd.latchLo = phase;
      end
      ST_VECH: begin
        cmd.addrSel = SEL_VECTOR;
        cmd.vecHi   = 1'b1;
        cmd.rdStb   = 1'b1;
        cmd.latchHi = phase;
      end
      ST_PCOUT, ST_FIN: cmd.addrSel = SEL_START;
      default: ;
    endcase
  end

  assign intRst = (state == ST_HOLD);
  assign done   = (state == ST_PCOUT);

endmodule

// File: rtl/reset_vector_seq.sv
module reset_vector_seq
  import rvs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_DIV   = 16,
  parameter int T_LO_INIT   = 255,
  parameter int T_HI_INIT   = 7,
  parameter int STACK_PAGE  = 1,
  parameter int VEC_ADDR    = 16'hFFFE
) (
  input  logic                clk,
  input  logic                rstExtN,
  input  logic [DATA_W-1:0]   spInit,
  input  logic [DATA_W-1:0]   rdData,
  output logic                intRst,
  output logic                phiEn,
  output logic [2*DATA_W-1:0] addr,
  output logic                rdStb,
  output logic [2*DATA_W-1:0] startPc,
  output logic                done
);

  logic    rstSyncN;
  logic    expire;
  logic    phase;
  seqCmd_t cmd;

  rvs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .asyncN (rstExtN),
    .syncN  (rstSyncN)
  );

  rvs_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstSyncN),
    .expire (expire),
    .phase  (phase),
    .cmd    (cmd),
    .intRst (intRst),
    .done   (done)
  );

  rvs_datapath #(
    .DATA_W     (DATA_W),
    .PRESC_DIV  (PRESC_DIV),
    .T_LO_INIT  (T_LO_INIT),
    .T_HI_INIT  (T_HI_INIT),
    .STACK_PAGE (STACK_PAGE),
    .VEC_ADDR   (VEC_ADDR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstSyncN),
    .cmd     (cmd),
    .spInit  (spInit),
    .rdData  (rdData),
    .expire  (expire),
    .phase   (phase),
    .addr    (addr),
    .startPc (startPc)
  );

  assign phiEn = phase;
  assign rdStb = cmd.rdStb;

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRESC_DIV   = 16,
  parameter int T_LO_INIT   = 255,
  parameter int T_HI_INIT   = 7,
  parameter int VEC_ADDR    = 16'hFFFE
) (
  input logic                clk,
  input logic                rstExtN,
  input logic                intRst,
  input logic                phiEn,
  input logic [2*DATA_W-1:0] addr,
  input logic                rdStb,
  input logic [2*DATA_W-1:0] startPc,
  input logic                done
);

  localparam int AW = 2 * DATA_W;
  localparam int RELEASE_EDGES =
    SYNC_STAGES + PRESC_DIV * (T_LO_INIT + 1) * (T_HI_INIT + 1);
  localparam logic [AW-1:0] VEC = AW'(VEC_ADDR);

  int unsigned highEdges;

  always_ff @(posedge clk or negedge rstExtN) begin
    if (!rstExtN)                    highEdges <= 0;
    else if (highEdges != 32'hFFFF_FFFF) highEdges <= highEdges + 1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstExtN)
    intRst |-> (!phiEn && !rdStb && !done && addr == '0)); // R3

  AST_PHI_ALTERNATES: assert property (@(posedge clk) disable iff (!rstExtN)
    (!intRst && !$past(intRst)) |-> (phiEn != $past(phiEn))); // R1

  AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (!rstExtN)
    $fell(intRst) |-> (highEdges == RELEASE_EDGES)); // R2

  AST_STROBE_ON_VECTOR: assert property (@(posedge clk) disable iff (!rstExtN)
    rdStb |-> (addr[AW-1:1] == VEC[AW-1:1])); // R5

  AST_ADDR_HOLDS_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstExtN)
    (!intRst && !$past(intRst) && !$past(phiEn)) |-> $stable(addr)); // R4

  AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstExtN)
    $rose(done) |-> ($past(rdStb) && addr == startPc)); // R7

endmodule

bind reset_vector_seq rvs_checker #(
  .DATA_W      (DATA_W),
  .SYNC_STAGES (SYNC_STAGES),
  .PRESC_DIV   (PRESC_DIV),
  .T_LO_INIT   (T_LO_INIT),
  .T_HI_INIT   (T_HI_INIT),
  .VEC_ADDR    (VEC_ADDR)
) u_chk (.*);

// File: tb/reset_vector_seq_tb.sv
module reset_vector_seq_tb;

  localparam int CLK_PERIOD    = 10;
  localparam int RELEASE_EDGES = 32770;
  localparam int WATCHDOG      = 190000;

  logic        clk = 1'b0;
  logic        rstExtN = 1'b1;
  logic [7:0]  spInit = 8'h80;
  logic [7:0]  rdData;
  logic        intRst, phiEn, rdStb, done;
  logic [15:0] addr, startPc;
  logic [7:0]  vecLo = 8'h34;
  logic [7:0]  vecHi = 8'h12;

  int  checks = 0;
  int  errors = 0;
  int  edgesHigh = 0;
  int  cycles = 0;
  bit  armed = 1'b0;
  bit  rearmed = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural memory for the vector pair
  assign rdData = (addr == 16'hFFFE) ? vecLo :
                  (addr == 16'hFFFF) ? vecHi : 8'hEE;

  reset_vector_seq u_dut (
    .clk     (clk),
    .rstExtN (rstExtN),
    .spInit  (spInit),
    .rdData  (rdData),
    .intRst  (intRst),
    .phiEn   (phiEn),
    .addr    (addr),
    .rdStb   (rdStb),
    .startPc (startPc),
    .done    (done)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d",
               req, what, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rstExtN) edgesHigh++;
    else         edgesHigh = 0;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finishRun();
    end
  end

  // Reference model compared on every falling edge
  always @(negedge clk) begin
    if (armed) begin
      int n, m, idx;
      string tagHold;
      n = rstExtN ? edgesHigh : 0;
      tagHold = (n == 0) ? "R3" : (rearmed ? "R8" : "R2");
      if (n < RELEASE_EDGES) begin
        check(tagHold, "intRst", intRst, 1);
        check("R1", "phiEn", phiEn, 0);
        check("R3", "addr", addr, 16'h0000);
        check("R3", "rdStb", rdStb, 0);
        check("R3", "done", done, 0);
      end else begin
        m   = n - RELEASE_EDGES;
        idx = m / 2;
        check(rearmed ? "R8" : "R2", "intRst", intRst, 0);
        check("R1", "phiEn", phiEn, m % 2);
        if (idx < 3) begin
          check("R4", "addr", addr, {8'h01, spInit - 8'(idx)});
          check("R4", "rdStb", rdStb, 0);
        end else if (idx < 5) begin
          check("R5", "addr", addr, (idx == 3) ? 16'hFFFE : 16'hFFFF);
          check("R5", "rdStb", rdStb, 1);
        end else begin
          check("R6", "addr", addr, {vecHi, vecLo});
          check("R6", "startPc", startPc, {vecHi, vecLo});
          check("R6", "rdStb", rdStb, 0);
        end
        check("R7", "done", done, (idx == 5) ? 1 : 0);
      end
    end
  end

  task automatic releaseReset();
    @(negedge clk);
    #1 rstExtN = 1'b1;
  endtask

  task automatic pulseReset(input int lowCycles);
    @(negedge clk);
    #1 rstExtN = 1'b0;
    repeat (lowCycles) @(negedge clk);
  endtask

  // Explicit measurement of the release delay in crystal cycles
  task automatic measureDelay(input string req);
    int count = 0;
    @(negedge clk);
    #1 rstExtN = 1'b1;
    while (1) begin
      @(negedge clk);
      count++;
      if (!intRst) break;
      if (count > RELEASE_EDGES + 10) break;
    end
    check(req, "release edge count", count, RELEASE_EDGES);
  endtask

  initial begin
    #1 rstExtN = 1'b0;
    repeat (4) @(negedge clk);
    armed = 1'b1;
    repeat (3) @(negedge clk);

    // Run 1: S = 0x80, start address 0x1234
    measureDelay("R2");
    repeat (20) @(negedge clk);

    // Run 2: re-arm part-way through the delay
    pulseReset(3);
    rearmed = 1'b1;
    releaseReset();
    repeat (10000) @(posedge clk);
    pulseReset(3);
    measureDelay("R8");
    repeat (20) @(negedge clk);

    // Run 3: re-arm during the low vector read, then new S and vector
    pulseReset(3);
    releaseReset();
    repeat (RELEASE_EDGES + 7) @(posedge clk);
    pulseReset(1);
    spInit = 8'h01;
    vecLo  = 8'hEF;
    vecHi  = 8'hBE;
    repeat (2) @(negedge clk);
    measureDelay("R8");
    repeat (20) @(negedge clk);
    check("R6", "final startPc", startPc, 16'hBEEF);

    finishRun();
  end

endmodule